// File: doc/BRIEF.md
# Quadrature 4x Decoder with Position Counter

This block turns two clean, clock-synchronous quadrature channels into a signed-agnostic 16-bit position count. Every edge on either channel advances the count by one, so a full electrical cycle of the encoder yields four counts. Each clock, the block compares the channel pair sampled now with the pair sampled one clock earlier. It decides whether the shaft stepped forward, stepped back, did not move, or skipped a state.

The pair (A,B) walks a four-phase Gray cycle: phase 0 is (1,0), phase 1 is (1,1), phase 2 is (0,1) and phase 3 is (0,0). Moving to the next phase (A leading B) counts up. Moving to the previous phase (B leading A) counts down. A jump of two phases in one sample cannot be resolved into a direction. The count is left alone and a one-cycle flag is raised instead. The counter wraps freely in both directions, so host software can form movement as a two's-complement difference of two readings. The inputs are expected to be filtered and synchronised upstream, and to hold each phase for at least one clock.

Top module: `quad_decoder_4x`

## Requirements
- R1: While rst_n is sampled low on a rising edge, position is cleared to 0 and bad_step is cleared to 0.
- R2: When the phase of (A,B) sampled on an edge is one greater (mod 4) than the phase sampled on the previous edge, position increases by 1, with phases (1,0)=0, (1,1)=1, (0,1)=2, (0,0)=3.
- R3: When the sampled phase is one less (mod 4) than the previous sampled phase, position decreases by 1.
- R4: When the sampled (A,B) equals the previous sample, position is unchanged and bad_step is 0.
- R5: When the sampled phase differs from the previous one by two, position is unchanged and bad_step is 1 for that one cycle.
- R6: Counting up from 16'hFFFF gives 16'h0000, and counting down from 16'h0000 gives 16'hFFFF.
- R7: The first sample after reset is compared against the inputs present during reset, so releasing reset produces no count and no flag while the inputs do not change.
- R8: position and bad_step take their new values on the same rising edge that first samples the new (A,B) pair.
- R9: Four consecutive forward phase steps change position by exactly +4, and four backward steps by exactly -4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_a | input | 1 | Filtered quadrature channel A |
| chan_b | input | 1 | Filtered quadrature channel B |
| position | output | 16 | Wrapping up/down position count |
| bad_step | output | 1 | One-cycle flag for a two-phase jump |

## Verification
Every cycle, assertions relate the input phase change to the next count: a forward step must add one, a backward step must subtract one, an unchanged input must leave both outputs quiet, and a two-phase jump must hold the count and raise the flag. The counter also carries a check that the count never moves by more than one per clock. The bench's scenarios cover the rest: the count read after reset, the absence of a count when reset is released, wraparound in both directions, full four-count cycles, and agreement with a bench model over a long random walk.

// File: rtl/quad_pkg.sv
// Package: shared step encoding and phase mapping for the quadrature decoder.
// Assumes channel inputs are already synchronous to clk.
package quad_pkg;

    // Outcome of comparing the previous and present channel samples.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_FWD  = 2'd1,
        STEP_BACK = 2'd2,
        STEP_SKIP = 2'd3
    } step_t;

    // Map the (A,B) pair onto its position in the four-phase Gray cycle:
    // (1,0)->0, (1,1)->1, (0,1)->2, (0,0)->3.
    function automatic logic [1:0] phase_of(input logic a, input logic b);
        return {~a, ~(a ^ b)};
    endfunction

endpackage

// File: rtl/quad_phase_tracker.sv
// Module: quad_phase_tracker
// Keeps the phase sampled on the previous clock and classifies the step
// to the present sample as hold, forward, backward or skip.
// Assumes: inputs synchronous; during reset the stored phase follows the
// inputs so that the first sample after reset sees no movement.
module quad_phase_tracker
    import quad_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  chan_a,
    input  logic  chan_b,
    output step_t step
);

    localparam int PH_W = 2;

    logic [PH_W-1:0] prev_ph;
    logic [PH_W-1:0] cur_ph;
    logic [PH_W-1:0] delta;

    assign cur_ph = phase_of(chan_a, chan_b);
    assign delta  = PH_W'(cur_ph - prev_ph);

    // Purpose: remember the phase of the last sample (loaded from inputs in reset).
    always_ff @(posedge clk) begin
        prev_ph <= cur_ph;
    end

    // Purpose: translate the modular phase difference into a step code.
    always_comb begin
        unique case (delta)
            2'd0:    step = STEP_HOLD;
            2'd1:    step = STEP_FWD;
            2'd3:    step = STEP_BACK;
            default: step = STEP_SKIP;
        endcase
    end

    // A held input pair must never be classified as movement (R4).
    p_hold_when_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $stable({chan_a, chan_b}) |-> (step == STEP_HOLD));

endmodule

// File: rtl/quad_pos_counter.sv
// Module: quad_pos_counter
// Wrapping up/down counter driven by the step code, plus the registered
// one-cycle flag for a skipped phase.
// Assumes: step is valid every cycle; reset is synchronous and active low.
module quad_pos_counter
    import quad_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_t            step,
    output logic [POS_W-1:0] position,
    output logic             bad_step
);

    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    logic [POS_W-1:0] pos_next;

    // Purpose: select the next count; overflow and underflow wrap naturally.
    always_comb begin
        unique case (step)
            STEP_FWD:  pos_next = position + ONE;
            STEP_BACK: pos_next = position - ONE;
            default:   pos_next = position;
        endcase
    end

    // Purpose: register the count and the skip flag with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            position <= '0;
            bad_step <= 1'b0;
        end else begin
            position <= pos_next;
            bad_step <= (step == STEP_SKIP);
        end
    end

    // The count moves by at most one per clock (R2, R3, R6 wrap included).
    p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((position == $past(position)) ||
                  (position == POS_W'($past(position) + ONE)) ||
                  (position == POS_W'($past(position) - ONE))));

    // A raised skip flag comes with an untouched count (R5).
    p_skip_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_step |-> $stable(position));

endmodule

// File: rtl/quad_decoder_4x.sv
// Module: quad_decoder_4x (top)
// 4x quadrature decoder: every edge of A or B moves a wrapping position
// count by one; two-phase jumps are flagged and not counted.
// Assumes: channels filtered and synchronous, each phase held >= 1 clock.
module quad_decoder_4x
    import quad_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_a,
    input  logic             chan_b,
    output logic [POS_W-1:0] position,
    output logic             bad_step
);

    step_t step;

    quad_phase_tracker u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .chan_a (chan_a),
        .chan_b (chan_b),
        .step   (step)
    );

    quad_pos_counter #(.POS_W(POS_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .position (position),
        .bad_step (bad_step)
    );

    // Forward phase step at the ports adds one on the next sample (R2, R8).
    p_fwd_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (2'(phase_of(chan_a, chan_b) - phase_of($past(chan_a), $past(chan_b))) == 2'd1)
        |=> (position == POS_W'($past(position) + POS_W'(1))) && !bad_step);

    // Backward phase step subtracts one (R3).
    p_back_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (2'(phase_of(chan_a, chan_b) - phase_of($past(chan_a), $past(chan_b))) == 2'd3)
        |=> (position == POS_W'($past(position) - POS_W'(1))) && !bad_step);

    // Unchanged inputs keep the outputs quiet (R4, R7).
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $stable({chan_a, chan_b}) |=> $stable(position) && !bad_step);

    // Two-phase jump is flagged and not counted (R5).
    p_jump_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (2'(phase_of(chan_a, chan_b) - phase_of($past(chan_a), $past(chan_b))) == 2'd2)
        |=> $stable(position) && bad_step);

endmodule

// File: tb/quad_decoder_4x_tb.sv
module quad_decoder_4x_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_a = 1'b1;
    logic        chan_b = 1'b0;
    logic [15:0] position;
    logic        bad_step;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [1:0]  m_ph;
    logic [15:0] m_pos;
    logic        m_flag;

    quad_decoder_4x u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_a   (chan_a),
        .chan_b   (chan_b),
        .position (position),
        .bad_step (bad_step)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench-side phase table from the requirement text (R2).
    function automatic logic [1:0] ph_to_bits(input logic [1:0] ph);
        case (ph)
            2'd0:    return 2'b10;
            2'd1:    return 2'b11;
            2'd2:    return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a new phase at the falling edge, let one rising edge sample it,
    // update the model, then check at the next falling edge (R8).
    task automatic step_to(input logic [1:0] ph, input string req);
        logic [1:0] d;
        logic [1:0] bits;
        @(negedge clk);
        bits   = ph_to_bits(ph);
        chan_a = bits[1];
        chan_b = bits[0];
        d = 2'(ph - m_ph);
        m_flag = 1'b0;
        if (d == 2'd1)      m_pos = m_pos + 16'd1;
        else if (d == 2'd3) m_pos = m_pos - 16'd1;
        else if (d == 2'd2) m_flag = 1'b1;
        m_ph = ph;
        @(posedge clk);
        @(negedge clk);
        check(req, position, m_pos);
        check(req, {15'd0, bad_step}, {15'd0, m_flag});
    endtask

    task automatic do_reset(input logic [1:0] ph);
        logic [1:0] bits;
        @(negedge clk);
        bits   = ph_to_bits(ph);
        chan_a = bits[1];
        chan_b = bits[0];
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", position, 16'd0);
        check("R1", {15'd0, bad_step}, 16'd0);
        rst_n  = 1'b0;
        m_ph   = ph;
        m_pos  = 16'd0;
        m_flag = 1'b0;
        rst_n  = 1'b1;
        // No input change across release: no spurious count (R7).
        repeat (2) @(negedge clk);
        check("R7", position, 16'd0);
        check("R7", {15'd0, bad_step}, 16'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL R8 watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        m_ph = 2'd0; m_pos = 16'd0; m_flag = 1'b0;

        // R1, R7: reset at phase 2, release without change.
        do_reset(2'd2);

        // R6: underflow from zero, then overflow back.
        step_to(2'd1, "R6");
        check("R6", position, 16'hFFFF);
        step_to(2'd2, "R6");
        check("R6", position, 16'h0000);

        // R9: full forward cycle, then full backward cycle.
        for (int i = 1; i <= 4; i++) step_to(2'(2 + i), "R9");
        check("R9", position, 16'd4);
        for (int i = 1; i <= 4; i++) step_to(2'(2 - i), "R9");
        check("R9", position, 16'd0);

        // R4: hold for several clocks.
        for (int i = 0; i < 3; i++) step_to(m_ph, "R4");

        // R5: two-phase jumps both ways, then a normal step afterwards.
        step_to(2'(m_ph + 2), "R5");
        step_to(2'(m_ph + 2), "R5");
        step_to(2'(m_ph + 1), "R2");
        step_to(2'(m_ph - 1), "R3");

        // Random walk mixing all step kinds (R2, R3, R4, R5).
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 16;
            if (r < 6)       step_to(2'(m_ph + 1), "R2");
            else if (r < 12) step_to(2'(m_ph - 1), "R3");
            else if (r < 14) step_to(m_ph, "R4");
            else             step_to(2'(m_ph + 2), "R5");
        end

        // Mid-run reset at a different phase (R1, R7), then count up (R2).
        do_reset(2'd3);
        step_to(2'd0, "R2");
        check("R2", position, 16'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule